// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Atomic Set, Clear and Toggle

This block is the data path of a 32-pin general-purpose I/O port that sits on a simple memory-mapped register bus. Software controls each pad through a per-pin direction bit and an output latch. The current pad levels are read back through a two-flop synchronizer.

Besides the plain output register, three write-only alias registers change chosen output bits in a single bus write. A write to the set alias drives the chosen bits high. A write to the clear alias drives them low. A write to the toggle alias inverts them. Each 1 in the written word selects a bit; a 0 leaves that bit as it is. Two software contexts can therefore drive different pins of the same port without a read-modify-write race.

A request is one cycle with `bus_sel` high. `bus_ready` answers it in the next cycle. In that same cycle `bus_rdata` carries the read data; it is 0 after a write and while the bus is idle.

Top module: `gpio_atomic_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, the output latch, the direction register and both synchronizer stages are cleared. After that edge `pad_out`, `pad_oe`, `bus_rdata` and `bus_ready` are all 0.
- R2: `bus_ready` is high in the cycle after each cycle in which `bus_sel` is high, and low otherwise. `bus_rdata` is 0 whenever the previous cycle was not a read.
- R3: Offset 0x00 (address bits [4:2] = 0) is the output latch. A write replaces it with `bus_wdata`, and a read returns its current value.
- R4: A write to offset 0x04 (index 1) sets each latch bit whose written bit is 1 and keeps every other bit.
- R5: A write to offset 0x08 (index 2) clears each latch bit whose written bit is 1 and keeps every other bit.
- R6: A write to offset 0x0C (index 3) inverts each latch bit whose written bit is 1 and keeps every other bit.
- R7: Reads of the set, clear and toggle aliases (indices 1 to 3) return 0.
- R8: Offset 0x10 (index 4) reads the synchronized pad inputs. A pad level that is present at clock edge k is returned by a read issued in the cycle after edge k+1, and by later reads. Writes to this offset change nothing.
- R9: Offset 0x14 (index 5) is the direction register, readable and writable. A 1 makes the pin an output. `pad_oe` equals this register at all times.
- R10: `pad_out` equals the output latch on every pin, whatever the pin's direction.
- R11: Address bits [1:0] are ignored. Indices 6 and 7 (offsets 0x18 and 0x1C) read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Request valid for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | Response strobe, one cycle after the request |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |

## Verification
The two functions that meet in one cycle are the synchronizer shifting a new pad value forward and a bus read of the input register capturing it. The bench changes `pad_in` on every cycle while it issues back-to-back reads of offset 0x10. Each returned word must match the pad value from exactly two edges before the capture edge, so an extra or a missing stage shows up at once. A second overlap is a read that directly follows an alias write. It is judged by requiring the read to return the latch value after the write.

// File: rtl/gpio_atomic_pkg.sv
// Package gpio_atomic_pkg
// Shared register indices and the latch-update operation type for the GPIO port.
// Assumes word-aligned registers, so the index is the byte address divided by 4.
package gpio_atomic_pkg;

    localparam int unsigned RS_DATA = 0;
    localparam int unsigned RS_SET  = 1;
    localparam int unsigned RS_CLR  = 2;
    localparam int unsigned RS_TOG  = 3;
    localparam int unsigned RS_IN   = 4;
    localparam int unsigned RS_DIR  = 5;

    typedef enum logic [2:0] {
        OP_HOLD = 3'd0,
        OP_LOAD = 3'd1,
        OP_SET  = 3'd2,
        OP_CLR  = 3'd3,
        OP_TOG  = 3'd4
    } latch_op_e;

endpackage

// File: rtl/gpio_bus_decode.sv
// Module gpio_bus_decode
// Turns one bus request into a latch operation, a direction-write strobe and a
// read select, and registers the one-cycle response strobe.
// Assumes one request per cycle. The caller has already dropped the byte-lane address bits.
module gpio_bus_decode
    import gpio_atomic_pkg::*;
#(
    parameter int unsigned IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [IDX_W-1:0] bus_idx,
    output latch_op_e        latch_op,
    output logic             dir_wr,
    output logic             rd_en,
    output logic [IDX_W-1:0] rd_idx,
    output logic             ready
);

    logic wr_en;
    assign wr_en  = bus_sel & bus_we;
    assign rd_en  = bus_sel & ~bus_we;
    assign rd_idx = bus_idx;

    // Map a write to its latch operation or to the direction strobe.
    always_comb begin
        latch_op = OP_HOLD;
        dir_wr   = 1'b0;
        if (wr_en) begin
            case (bus_idx)
                IDX_W'(RS_DATA): latch_op = OP_LOAD;
                IDX_W'(RS_SET):  latch_op = OP_SET;
                IDX_W'(RS_CLR):  latch_op = OP_CLR;
                IDX_W'(RS_TOG):  latch_op = OP_TOG;
                IDX_W'(RS_DIR):  dir_wr   = 1'b1;
                default:         latch_op = OP_HOLD;
            endcase
        end
    end

    // Response strobe: one cycle after each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) ready <= 1'b0;
        else        ready <= bus_sel;
    end

endmodule

// File: rtl/gpio_out_latch.sv
// Module gpio_out_latch
// Output data latch. Each bit is loaded, set, cleared or toggled according to the
// decoded operation, with the write data acting as the bit select.
// Assumes at most one operation per cycle.
module gpio_out_latch
    import gpio_atomic_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  latch_op_e        op,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic bit_q;
        logic bit_d;

        // Next value of this bit for the requested operation.
        always_comb begin
            case (op)
                OP_LOAD: bit_d = wdata[b];
                OP_SET:  bit_d = bit_q | wdata[b];
                OP_CLR:  bit_d = bit_q & ~wdata[b];
                OP_TOG:  bit_d = bit_q ^ wdata[b];
                default: bit_d = bit_q;
            endcase
        end

        // Bit storage with synchronous clear.
        always_ff @(posedge clk) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= bit_d;
        end

        assign q[b] = bit_q;
    end

endmodule

// File: rtl/gpio_dir_reg.sv
// Module gpio_dir_reg
// Per-pin direction register. A 1 marks the pin as an output.
// Assumes the write strobe comes from the bus decoder.
module gpio_dir_reg #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);

    // Load the whole word on a direction write.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (wr) q <= wdata;
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Module gpio_in_sync
// Multi-flop synchronizer for asynchronous pad inputs. Each bit is synchronized on
// its own, so bits that change together may show up one cycle apart.
// Assumes STAGES >= 1. The default of 2 gives a two-edge latency.
module gpio_in_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage [STAGES];

    // Shift the pad sample through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage[s] <= '0;
        end else begin
            stage[0] <= d;
            for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/gpio_atomic_port.sv
// Module gpio_atomic_port
// 32-pin GPIO data block. It holds an output latch with set, clear and toggle alias
// registers, a direction register and a synchronized input register, all on a
// single-cycle-response register bus. Pad outputs come straight from the latch, and
// the output enables come straight from the direction bits.
// Assumes ADDR_W >= 5 and PINS <= the bus data width, which is PINS itself.
module gpio_atomic_port
    import gpio_atomic_pkg::*;
#(
    parameter int unsigned PINS        = 32,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    output logic              bus_ready,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    latch_op_e        latch_op;
    logic             dir_wr;
    logic             rd_en;
    logic [IDX_W-1:0] rd_idx;
    logic [PINS-1:0]  out_q;
    logic [PINS-1:0]  dir_q;
    logic [PINS-1:0]  in_q;
    logic [PINS-1:0]  rd_mux;
    logic [1:0]       unused_byte_lane;

    assign unused_byte_lane = bus_addr[1:0];

    gpio_bus_decode #(.IDX_W(IDX_W)) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_idx  (bus_addr[ADDR_W-1:2]),
        .latch_op (latch_op),
        .dir_wr   (dir_wr),
        .rd_en    (rd_en),
        .rd_idx   (rd_idx),
        .ready    (bus_ready)
    );

    gpio_out_latch #(.WIDTH(PINS)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (latch_op),
        .wdata (bus_wdata),
        .q     (out_q)
    );

    gpio_dir_reg #(.WIDTH(PINS)) u_dir (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (dir_wr),
        .wdata (bus_wdata),
        .q     (dir_q)
    );

    gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (in_q)
    );

    // Select the readable register. Aliases and unmapped slots return 0.
    always_comb begin
        case (rd_idx)
            IDX_W'(RS_DATA): rd_mux = out_q;
            IDX_W'(RS_IN):   rd_mux = in_q;
            IDX_W'(RS_DIR):  rd_mux = dir_q;
            default:         rd_mux = '0;
        endcase
    end

    // Register the read data so it lines up with the response strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (rd_en) bus_rdata <= rd_mux;
        else            bus_rdata <= '0;
    end

    assign pad_out = out_q;
    assign pad_oe  = dir_q;

endmodule

// File: rtl/gpio_atomic_port_chk.sv
// Module gpio_atomic_port_chk
// Property checker for gpio_atomic_port, attached through bind. It observes the
// ports only.
module gpio_atomic_port_chk #(
    parameter int unsigned PINS   = 32,
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PINS-1:0]   bus_wdata,
    input logic [PINS-1:0]   bus_rdata,
    input logic              bus_ready,
    input logic [PINS-1:0]   pad_in,
    input logic [PINS-1:0]   pad_out,
    input logic [PINS-1:0]   pad_oe
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic [1:0]       unused_lane;
    logic             wr;
    logic             rd;

    assign idx         = bus_addr[ADDR_W-1:2];
    assign unused_lane = bus_addr[1:0];
    assign wr          = bus_sel & bus_we;
    assign rd          = bus_sel & ~bus_we;

    // R1: a reset edge leaves every output quiet.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (pad_out == '0 && pad_oe == '0 && !bus_ready && bus_rdata == '0));

    // R2: a request is answered in the next cycle.
    a_r2_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |=> bus_ready);

    // R2: no response without a request.
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> (!bus_ready && bus_rdata == '0));

    // R3: a write to the data register loads the latch.
    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx == IDX_W'(0)) |=> pad_out == $past(bus_wdata));

    // R4: the set alias ORs into the latch.
    a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx == IDX_W'(1)) |=> pad_out == ($past(pad_out) | $past(bus_wdata)));

    // R5: the clear alias masks the latch.
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx == IDX_W'(2)) |=> pad_out == ($past(pad_out) & ~$past(bus_wdata)));

    // R6: the toggle alias XORs into the latch.
    a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx == IDX_W'(3)) |=> pad_out == ($past(pad_out) ^ $past(bus_wdata)));

    // R7: alias reads return 0.
    a_r7_alias_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && idx >= IDX_W'(1) && idx <= IDX_W'(3)) |=> bus_rdata == '0);

    // R8: an input read returns the pad value from two edges before the capture.
    a_r8_input_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && idx == IDX_W'(4) && $past(rst_n) && $past(rst_n, 2))
        |=> bus_rdata == $past(pad_in, 3));

    // R8: writes to the input register change no output.
    a_r8_input_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx == IDX_W'(4)) |=> ($stable(pad_out) && $stable(pad_oe)));

    // R9: a direction write drives the output enables.
    a_r9_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx == IDX_W'(5)) |=> pad_oe == $past(bus_wdata));

    // R10: the data register read-back equals the pad output.
    a_r10_pad_matches_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && idx == IDX_W'(0)) |=> bus_rdata == $past(pad_out));

    // R11: unmapped slots have no effect and read 0.
    a_r11_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && idx >= IDX_W'(6)) |=> ($stable(pad_out) && $stable(pad_oe) && bus_rdata == '0));

endmodule

bind gpio_atomic_port gpio_atomic_port_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/gpio_atomic_port_bench.sv
`timescale 1ns/1ps
module gpio_atomic_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic [31:0] pad_in = 32'h1234_5678;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    gpio_atomic_port u_gpio_atomic_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Behavioural reference model
    logic [31:0] m_out = '0, m_dir = '0, m_rdata = '0;
    logic        m_ready = 1'b0;
    logic [31:0] pad_hist[$];
    string       t_out = "R1", t_rd = "R1";

    always @(posedge clk) begin
        int idx;
        idx = int'(bus_addr >> 2);
        if (!rst_n) begin
            m_out = '0; m_dir = '0; m_rdata = '0; m_ready = 1'b0;
            pad_hist = {32'h0, 32'h0};
            t_out = "R1"; t_rd = "R1";
        end else begin
            m_ready = bus_sel;
            m_rdata = '0;
            t_rd = "R2";
            if (bus_sel && !bus_we) begin
                case (idx)
                    0: begin m_rdata = m_out; t_rd = "R3"; end
                    1, 2, 3: t_rd = "R7";
                    4: begin m_rdata = pad_hist[0]; t_rd = "R8"; end
                    5: begin m_rdata = m_dir; t_rd = "R9"; end
                    default: t_rd = "R11";
                endcase
            end
            if (bus_sel && bus_we) begin
                case (idx)
                    0: begin m_out = bus_wdata; t_out = "R3"; end
                    1: begin m_out = m_out | bus_wdata; t_out = "R4"; end
                    2: begin m_out = m_out & ~bus_wdata; t_out = "R5"; end
                    3: begin m_out = m_out ^ bus_wdata; t_out = "R6"; end
                    4: t_out = "R8";
                    5: begin m_dir = bus_wdata; t_out = "R9"; end
                    default: t_out = "R11";
                endcase
            end
            void'(pad_hist.pop_front());
            pad_hist.push_back(pad_in);
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            chk(t_out, "pad_out", pad_out, m_out);
            chk("R9", "pad_oe", pad_oe, m_dir);
            chk("R2", "bus_ready", {31'b0, bus_ready}, {31'b0, m_ready});
            chk(t_rd, "bus_rdata", bus_rdata, m_rdata);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic xfer(input logic we, input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        bus_sel = 1'b0; bus_we = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs are quiet while in reset
        chk("R1", "reset pad_oe", pad_oe, 32'h0);
        chk("R1", "reset pad_out", pad_out, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3, R9: read after reset, then load and read back
        xfer(0, 5'h00, 0); xfer(0, 5'h14, 0); xfer(0, 5'h10, 0);
        xfer(1, 5'h00, 32'hA5A5_0F0F); xfer(0, 5'h00, 0);
        xfer(1, 5'h14, 32'hFFFF_0000); xfer(0, 5'h14, 0);
        // R4 R5 R6 back-to-back alias writes, each followed by a read
        xfer(1, 5'h04, 32'h0000_00F0); xfer(0, 5'h00, 0);
        xfer(1, 5'h08, 32'h0F00_0001); xfer(0, 5'h00, 0);
        xfer(1, 5'h0C, 32'hFFFF_FFFF); xfer(1, 5'h0C, 32'h0000_0001); xfer(0, 5'h00, 0);
        // R7: aliases read 0
        xfer(0, 5'h04, 0); xfer(0, 5'h08, 0); xfer(0, 5'h0C, 0);
        // R8: write to input register is ignored
        xfer(1, 5'h10, 32'hDEAD_BEEF); xfer(0, 5'h00, 0); xfer(0, 5'h14, 0);
        // R11: unmapped slots and byte-lane bits
        xfer(1, 5'h18, 32'hFFFF_FFFF); xfer(1, 5'h1C, 32'hFFFF_FFFF);
        xfer(0, 5'h18, 0); xfer(0, 5'h1F, 0);
        xfer(1, 5'h05, 32'h8000_0000); xfer(0, 5'h03, 0);
        idle(2);

        // R10: input-direction pins still show the latch
        xfer(1, 5'h14, 32'h0); xfer(1, 5'h00, 32'h3C3C_C3C3); idle(1);
        chk("R10", "pad_out with pins as inputs", pad_out, 32'h3C3C_C3C3);

        // R8: pad changes every cycle while the input register is read back-to-back
        for (int i = 0; i < 16; i++) begin
            pad_in = 32'h0101_0101 * (i + 1) ^ {i[7:0], 24'h5A5A5A};
            xfer(0, 5'h10, 0);
        end
        idle(3);

        // Mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            pad_in = $urandom;
            if (r[0]) xfer(r[1], {r[4:2], r[6:5]}, $urandom);
            else idle(1);
        end
        idle(2);

        // R1: reset in the middle of traffic
        xfer(1, 5'h00, 32'hFFFF_FFFF); xfer(1, 5'h14, 32'hFFFF_FFFF);
        rst_n = 1'b0; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 5'h04; bus_wdata = '1;
        @(negedge clk);
        chk("R1", "mid-run reset pad_out", pad_out, 32'h0);
        chk("R1", "mid-run reset pad_oe", pad_oe, 32'h0);
        chk("R1", "mid-run reset ready", {31'b0, bus_ready}, 32'h0);
        rst_n = 1'b1; idle(2);
        xfer(0, 5'h10, 0); idle(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule